// File: doc/BRIEF.md
# Burst Beat Address Sequencer

This block follows a bus burst beat by beat and produces the address that each beat must carry. A new burst is opened with a start address, a burst kind and a transfer size. After that, every accepted transfer steps the block to the next beat. Incrementing kinds add the transfer size in bytes to the address. Wrapping kinds keep the address inside a window whose span is the size times the beat count, and only the low bits inside that window roll over. The upper bits stay fixed.

Alongside the address the block reports a beat index and a flag that is high on the final beat of a fixed-length burst. It also reports a sticky error. The error is raised when the start address is not aligned to the size, when the size is wider than the data bus, when a wrap window would be larger than the protected address region, or when an incrementing step would carry over that region's boundary. The region is 1 KB by default. A cycle with no accepted transfer, such as a bus wait or a master pause, leaves everything unchanged. Bursts of unspecified length end only when a new burst starts or the idle input is raised.

All pins are plain control and status signals. There is no handshake: the caller raises `step_i` only for a transfer that the bus has accepted.

Top module: `burst_addr_gen`

## Requirements
- R1: While reset is held and in the first cycle after it, `addr_o`, `beat_o`, `last_o`, `active_o` and `err_o` are all zero.
- R2: One cycle after `start_i`, `addr_o` equals the start address, `beat_o` is 0 and `active_o` is 1. `start_i` takes priority over `step_i` and `idle_i`.
- R3: For burst kinds 000 (single), 001 (unspecified-length increment), 011, 101 and 111 (increment by 4, 8 and 16 beats), each accepted step adds 2^`size_i` bytes to the address (modulo the address width) and adds 1 to `beat_o`.
- R4: For burst kinds 010, 100 and 110 (wrap 4, 8 and 16 beats), a step adds 2^size to the address. Only the low size+log2(beats) bits take the new value; the bits above them keep their old value.
- R5: `last_o` is high exactly when a burst is active, is of fixed length and `beat_o` equals the beat count minus one (beat 0 for kind 000). It is never high for kind 001.
- R6: A step taken on the last beat ends the burst: `active_o` falls and `addr_o` and `beat_o` hold. Later steps are ignored until the next start.
- R7: A cycle without `step_i`, `start_i` or `idle_i` leaves `addr_o` and `beat_o` unchanged.
- R8: After a start, `err_o` is 1 if the start address has any of its low `size_i` bits set, or if `size_i` exceeds BUS_LG.
- R9: `err_o` is set by an incrementing step whose next address differs from the current one in any bit at or above BOUND_LG. It stays set until the next start.
- R10: After a start of a wrapping kind, `err_o` is 1 if size+log2(beats) exceeds BOUND_LG.
- R11: `idle_i` without `start_i` ends an active burst (`active_o` falls). This is how an unspecified-length burst is closed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Open a new burst with the start fields below |
| start_addr_i | input | ADDR_W | First beat address |
| burst_i | input | 3 | Burst kind encoding (see R3, R4) |
| size_i | input | 3 | Transfer size, log2 of bytes |
| step_i | input | 1 | Current beat accepted, advance |
| idle_i | input | 1 | End the current burst |
| addr_o | output | ADDR_W | Address of the current beat |
| beat_o | output | BEAT_W | Beat index within the burst (saturating) |
| last_o | output | 1 | Current beat is the final one of a fixed burst |
| active_o | output | 1 | A burst is in progress |
| err_o | output | 1 | Sticky alignment, width or boundary error |

## Verification
The bench builds the block with a 10-bit address, a bus width of 8 bytes (BUS_LG=3) and a protected region of 64 bytes (BOUND_LG=6). Shrinking the region lets a 16-beat wrap of 8-byte transfers exceed it, so the window-size error becomes reachable. It also makes incrementing bursts cross a region boundary often. The bench sweeps every burst kind, sizes 0 to 4 and 64 spread start addresses, some of them misaligned. For each beat it computes the address, last flag and error in plain arithmetic. Paused cycles, ends after the last beat, idle closing and start priority are checked inside the same sweep.

// File: rtl/burst_addr_pkg.sv
package burst_addr_pkg;

  typedef enum logic [2:0] {
    BK_ONE    = 3'b000,
    BK_OPEN   = 3'b001,
    BK_WRAP4  = 3'b010,
    BK_INC4   = 3'b011,
    BK_WRAP8  = 3'b100,
    BK_INC8   = 3'b101,
    BK_WRAP16 = 3'b110,
    BK_INC16  = 3'b111
  } burst_kind_e;

endpackage

// File: rtl/burst_kind_decode.sv
module burst_kind_decode
  import burst_addr_pkg::*;
(
  input  burst_kind_e kind,
  output logic        is_wrap,
  output logic [2:0]  len_lg
);
  always_comb begin
    is_wrap = 1'b0;
    len_lg  = 3'd0;
    unique case (kind)
      BK_ONE:    len_lg = 3'd0;
      BK_OPEN:   len_lg = 3'd0;
      BK_WRAP4:  begin is_wrap = 1'b1; len_lg = 3'd2; end
      BK_INC4:   len_lg = 3'd2;
      BK_WRAP8:  begin is_wrap = 1'b1; len_lg = 3'd3; end
      BK_INC8:   len_lg = 3'd3;
      BK_WRAP16: begin is_wrap = 1'b1; len_lg = 3'd4; end
      BK_INC16:  len_lg = 3'd4;
      default:   len_lg = 3'd0;
    endcase
  end
endmodule

// File: rtl/burst_addr_step.sv
module burst_addr_step #(
  parameter int ADDR_W   = 32,
  parameter int BOUND_LG = 10
) (
  input  logic [ADDR_W-1:0] cur_addr,
  input  logic [2:0]        size,
  input  logic              is_wrap,
  input  logic [2:0]        len_lg,
  output logic [ADDR_W-1:0] next_addr,
  output logic              crosses
);
  logic [ADDR_W-1:0] stride;
  logic [ADDR_W-1:0] summed;
  logic [ADDR_W-1:0] win_mask;
  logic [4:0]        win_lg;

  always_comb begin
    stride   = ADDR_W'(1) << size;
    summed   = cur_addr + stride;
    win_lg   = {2'b00, size} + {2'b00, len_lg};
    win_mask = (ADDR_W'(1) << win_lg) - ADDR_W'(1);
    if (is_wrap) begin
      next_addr = (cur_addr & ~win_mask) | (summed & win_mask);
      crosses   = 1'b0;
    end else begin
      next_addr = summed;
      crosses   = (summed >> BOUND_LG) != (cur_addr >> BOUND_LG);
    end
  end
endmodule

// File: rtl/burst_start_check.sv
module burst_start_check #(
  parameter int ADDR_W   = 32,
  parameter int BUS_LG   = 7,
  parameter int BOUND_LG = 10
) (
  input  logic [ADDR_W-1:0] start_addr,
  input  logic [2:0]        size,
  input  logic              is_wrap,
  input  logic [2:0]        len_lg,
  output logic              bad
);
  localparam logic [2:0] BUS_LIM   = 3'(BUS_LG);
  localparam logic [4:0] BOUND_LIM = 5'(BOUND_LG);

  logic [ADDR_W-1:0] low_mask;
  logic [4:0]        win_lg;
  logic              misaligned;
  logic              too_wide;
  logic              window_big;

  always_comb begin
    low_mask   = (ADDR_W'(1) << size) - ADDR_W'(1);
    misaligned = |(start_addr & low_mask);
    too_wide   = size > BUS_LIM;
    win_lg     = {2'b00, size} + {2'b00, len_lg};
    window_big = is_wrap && (win_lg > BOUND_LIM);
    bad        = misaligned || too_wide || window_big;
  end
endmodule

// File: rtl/burst_beat_track.sv
module burst_beat_track #(
  parameter int BEAT_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  logic              advance,
  input  logic              active,
  input  logic              fixed_len,
  input  logic [2:0]        len_lg,
  output logic [BEAT_W-1:0] beat,
  output logic              last
);
  localparam logic [BEAT_W-1:0] SAT = '1;

  logic [BEAT_W-1:0] beat_q;
  logic [BEAT_W-1:0] final_idx;

  always_comb begin
    final_idx = BEAT_W'((32'd1 << len_lg) - 32'd1);
    last      = active && fixed_len && (beat_q == final_idx);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      beat_q <= '0;
    end else if (clear) begin
      beat_q <= '0;
    end else if (advance && !last && beat_q != SAT) begin
      beat_q <= beat_q + BEAT_W'(1);
    end
  end

  assign beat = beat_q;
endmodule

// File: rtl/burst_addr_gen.sv
module burst_addr_gen
  import burst_addr_pkg::*;
#(
  parameter int ADDR_W   = 32,
  parameter int BUS_LG   = 7,
  parameter int BOUND_LG = 10,
  parameter int BEAT_W   = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [ADDR_W-1:0] start_addr_i,
  input  logic [2:0]        burst_i,
  input  logic [2:0]        size_i,
  input  logic              step_i,
  input  logic              idle_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic [BEAT_W-1:0] beat_o,
  output logic              last_o,
  output logic              active_o,
  output logic              err_o
);
  logic [ADDR_W-1:0] addr_q;
  logic [2:0]        size_q;
  burst_kind_e       kind_q;
  logic              active_q;
  logic              err_q;

  logic              cur_wrap, new_wrap;
  logic [2:0]        cur_len_lg, new_len_lg;
  logic [ADDR_W-1:0] next_addr;
  logic              step_cross;
  logic              start_bad;
  logic              fixed_len;
  logic              at_last;
  logic              take_step;

  burst_kind_decode u_dec_cur (
    .kind    (kind_q),
    .is_wrap (cur_wrap),
    .len_lg  (cur_len_lg)
  );

  burst_kind_decode u_dec_new (
    .kind    (burst_kind_e'(burst_i)),
    .is_wrap (new_wrap),
    .len_lg  (new_len_lg)
  );

  burst_addr_step #(.ADDR_W(ADDR_W), .BOUND_LG(BOUND_LG)) u_step (
    .cur_addr  (addr_q),
    .size      (size_q),
    .is_wrap   (cur_wrap),
    .len_lg    (cur_len_lg),
    .next_addr (next_addr),
    .crosses   (step_cross)
  );

  burst_start_check #(.ADDR_W(ADDR_W), .BUS_LG(BUS_LG), .BOUND_LG(BOUND_LG)) u_chk_start (
    .start_addr (start_addr_i),
    .size       (size_i),
    .is_wrap    (new_wrap),
    .len_lg     (new_len_lg),
    .bad        (start_bad)
  );

  assign fixed_len = (kind_q != BK_OPEN);
  assign take_step = step_i && active_q && !start_i && !idle_i;

  burst_beat_track #(.BEAT_W(BEAT_W)) u_beats (
    .clk       (clk),
    .rst_n     (rst_n),
    .clear     (start_i),
    .advance   (take_step),
    .active    (active_q),
    .fixed_len (fixed_len),
    .len_lg    (cur_len_lg),
    .beat      (beat_o),
    .last      (at_last)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q   <= '0;
      size_q   <= '0;
      kind_q   <= BK_ONE;
      active_q <= 1'b0;
      err_q    <= 1'b0;
    end else if (start_i) begin
      addr_q   <= start_addr_i;
      size_q   <= size_i;
      kind_q   <= burst_kind_e'(burst_i);
      active_q <= 1'b1;
      err_q    <= start_bad;
    end else if (idle_i) begin
      active_q <= 1'b0;
    end else if (take_step) begin
      if (at_last) begin
        active_q <= 1'b0;
      end else begin
        addr_q <= next_addr;
        err_q  <= err_q | step_cross;
      end
    end
  end

  assign addr_o   = addr_q;
  assign last_o   = at_last;
  assign active_o = active_q;
  assign err_o    = err_q;
endmodule

// File: rtl/burst_addr_gen_chk.sv
module burst_addr_gen_chk #(
  parameter int ADDR_W = 32,
  parameter int BEAT_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start_i,
  input logic              step_i,
  input logic              idle_i,
  input logic [ADDR_W-1:0] addr_o,
  input logic [BEAT_W-1:0] beat_o,
  input logic              last_o,
  input logic              active_o,
  input logic              err_o
);
  p_start_opens_r2: assert property (@(posedge clk) disable iff (!rst_n)
    start_i |=> (active_o && beat_o == '0));

  p_last_needs_active_r5: assert property (@(posedge clk) disable iff (!rst_n)
    last_o |-> active_o);

  p_end_after_last_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (last_o && step_i && !start_i && !idle_i) |=> (!active_o && $stable(addr_o)));

  p_hold_when_paused_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!start_i && !step_i && !idle_i) |=> ($stable(addr_o) && $stable(beat_o)));

  p_err_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (err_o && !start_i) |=> err_o);

  p_idle_closes_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (idle_i && !start_i) |=> !active_o);
endmodule

bind burst_addr_gen burst_addr_gen_chk #(.ADDR_W(ADDR_W), .BEAT_W(BEAT_W)) u_bind_chk (.*);

// File: tb/burst_addr_gen_test.sv
`timescale 1ns/1ps
module burst_addr_gen_test;
  localparam int AW = 10;
  localparam int BL = 3;
  localparam int BD = 6;
  localparam int BW = 6;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start_i = 1'b0;
  logic [AW-1:0] start_addr_i = '0;
  logic [2:0]    burst_i = '0;
  logic [2:0]    size_i = '0;
  logic          step_i = 1'b0;
  logic          idle_i = 1'b0;
  logic [AW-1:0] addr_o;
  logic [BW-1:0] beat_o;
  logic          last_o, active_o, err_o;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #5 clk = ~clk;

  burst_addr_gen #(.ADDR_W(AW), .BUS_LG(BL), .BOUND_LG(BD), .BEAT_W(BW)) uut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .start_addr_i(start_addr_i),
    .burst_i(burst_i), .size_i(size_i), .step_i(step_i), .idle_i(idle_i),
    .addr_o(addr_o), .beat_o(beat_o), .last_o(last_o), .active_o(active_o),
    .err_o(err_o)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    int a, st, sb, lenlg, len, wl, nb, n, msk;
    bit wrap, fixed, e;
    tick();
    chk(addr_o == 0 && beat_o == 0 && !last_o && !active_o && !err_o,
        "R1", "reset outputs", int'(addr_o), 0);
    rst_n = 1'b1;
    tick();
    chk(!active_o && addr_o == 0 && !err_o, "R1", "after reset", int'(active_o), 0);

    for (int b = 0; b < 8; b++) begin
      for (int sz = 0; sz < 5; sz++) begin
        for (int s = 0; s < 64; s++) begin
          st    = (s * 37 + b * 3) % 1024;
          wrap  = (b == 2 || b == 4 || b == 6);
          fixed = (b != 1);
          lenlg = (b < 2) ? 0 : (b < 4) ? 2 : (b < 6) ? 3 : 4;
          len   = 1 << lenlg;
          sb    = 1 << sz;
          wl    = sz + lenlg;
          e     = (st % sb != 0) || (sz > BL) || (wrap && wl > BD);
          nb    = fixed ? len : 20;
          a     = st;

          start_i = 1'b1; start_addr_i = AW'(st); burst_i = 3'(b); size_i = 3'(sz);
          step_i = 1'b1;  // start wins over a concurrent step (R2)
          tick();
          start_i = 1'b0; step_i = 1'b0;
          chk(active_o, "R2", "active after start", int'(active_o), 1);
          chk(err_o == e, (wrap && wl > BD) ? "R10" : "R8", "start error", int'(err_o), int'(e));

          for (int k = 0; k < nb; k++) begin
            chk(int'(addr_o) == a, wrap ? "R4" : "R3", "beat address", int'(addr_o), a);
            chk(int'(beat_o) == k, "R3", "beat index", int'(beat_o), k);
            chk(last_o == (fixed && k == len - 1), "R5", "last flag", int'(last_o),
                int'(fixed && k == len - 1));
            chk(err_o == e, "R9", "error flag", int'(err_o), int'(e));
            if (k == 1) begin
              tick();
              chk(int'(addr_o) == a && int'(beat_o) == k, "R7", "paused hold",
                  int'(addr_o), a);
            end
            step_i = 1'b1;
            tick();
            step_i = 1'b0;
            if (!(fixed && k == len - 1)) begin
              n = (a + sb) & 1023;
              if (wrap) begin
                msk = (1 << wl) - 1;
                n = (a & ~msk) | (n & msk);
              end else if ((n >> BD) != (a >> BD)) begin
                e = 1;
              end
              a = n;
            end
          end

          if (fixed) begin
            chk(!active_o, "R6", "ended after last", int'(active_o), 0);
            step_i = 1'b1;
            tick();
            step_i = 1'b0;
            chk(int'(addr_o) == a && int'(beat_o) == len - 1 && !active_o, "R6",
                "step after end ignored", int'(addr_o), a);
          end else begin
            chk(active_o && !last_o, "R5", "open burst never last", int'(last_o), 0);
            idle_i = 1'b1;
            tick();
            idle_i = 1'b0;
            chk(!active_o && int'(addr_o) == a, "R11", "idle closes", int'(active_o), 0);
          end
        end
      end
    end
    finish_run();
  end
endmodule